// File: doc/BRIEF.md
# Priority Interrupt Controller

The block collects a parameterised set of interrupt lines and turns them into one request line for a processor. Each line is fixed at build time as edge-sensitive or level-sensitive. A status bit for each line records its request. Software masks lines through an enable register, clears handled requests through an acknowledge register, and reads a vector register to learn the index of the most urgent request. Line 0 is the most urgent.

A master register controls the request output. Bit 0 gates the output. Bit 1 moves the block from software-driven requests to the hardware lines. Before bit 1 is set, the hardware lines are ignored and software can raise status bits by writing a set register, which is useful for bring-up. Bit 1 cannot be cleared again except by reset.

The register port is a plain synchronous write port and a combinational read port. The number of lines `N_SRC` must not exceed the data width `BUS_W`, which is 8, 16 or 32.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, the vector reads all ones and `irq_out` is low.
- R2: The vector register returns the lowest index whose status and enable bits are both set, or all ones when there is no such index.
- R3: The pending register returns status AND enable. A disabled line does not affect the vector or `irq_out`.
- R4: `irq_out` is high exactly when master bit 0 is set and at least one pending bit is set.
- R5: Master bit 1 (hardware mode) is set by writing 1 and stays set until reset. While it is clear, the hardware lines have no effect on status.
- R6: While hardware mode is clear, writing 1s to the set register sets the matching status bits. Once hardware mode is set, writes to this register are ignored.
- R7: In hardware mode, a rising edge on an edge-sensitive line sets its status bit. The bit holds until a 1 is written to it in the acknowledge register. A rising edge in the same cycle as the acknowledge leaves the bit set.
- R8: In hardware mode, the status bit of a level-sensitive line is set in every cycle that the line is high, so an acknowledge has no effect while the line is high. Once the line is low, an acknowledge clears the bit.
- R9: The register offsets are: 0 status (read), 1 pending (read), 2 enable (read/write), 3 acknowledge (write), 4 vector (read), 5 master (read/write; bit 0 output enable, bit 1 hardware mode), 6 set (write). Offsets 3, 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register offset |
| wr_data | input | BUS_W | Write data |
| rd_addr | input | 3 | Read register offset |
| rd_data | output | BUS_W | Read data for `rd_addr` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is an edge-line rising edge that arrives in the same clock cycle as an acknowledge for that line. It needs an earlier acknowledge to clear the bit and a line that has fallen back low, so the table arranges that history over the steps before it. A similar case is a level line acknowledged while it is still high and then again after it has dropped. The bench also covers the one-way switch into hardware mode: it first shows that hardware lines are ignored and that set-register writes take effect, then shows the reverse, and finally shows that a reset brings the software path back.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int BUS_W = 32,
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] EDGE_SEL = {(N_SRC/2){1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq_out
);
  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_EN = 3'd2, A_ACK = 3'd3,
                         A_VEC = 3'd4, A_MST = 3'd5, A_SET = 3'd6;

  logic [N_SRC-1:0] status, enable, irq_q, hw_set, ack_m, sw_m, pend;
  logic             out_en, hw_mode;
  logic [BUS_W-1:0] vec;

  assign ack_m = (wr_en && wr_addr == A_ACK) ? wr_data[N_SRC-1:0] : '0;
  assign sw_m  = (wr_en && wr_addr == A_SET && !hw_mode) ? wr_data[N_SRC-1:0] : '0;
  assign pend  = status & enable;
  assign irq_out = out_en && (pend != '0);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_SEL[i]) begin : g_edge
      assign hw_set[i] = hw_mode && irq_in[i] && !irq_q[i];
    end else begin : g_level
      assign hw_set[i] = hw_mode && irq_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      enable  <= '0;
      irq_q   <= '0;
      out_en  <= 1'b0;
      hw_mode <= 1'b0;
    end else begin
      irq_q  <= irq_in;
      status <= (status & ~ack_m) | hw_set | sw_m;
      if (wr_en && wr_addr == A_EN) enable <= wr_data[N_SRC-1:0];
      if (wr_en && wr_addr == A_MST) begin
        out_en  <= wr_data[0];
        hw_mode <= hw_mode | wr_data[1];
      end
    end
  end

  always_comb begin
    vec = '1;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) vec = BUS_W'(i);
  end

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = BUS_W'(status);
      A_PEND:  rd_data = BUS_W'(pend);
      A_EN:    rd_data = BUS_W'(enable);
      A_VEC:   rd_data = vec;
      A_MST:   rd_data = BUS_W'({hw_mode, out_en});
      default: rd_data = '0;
    endcase
  end

  // R5
  hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |=> hw_mode);

  // R2
  vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> pend[vec[$clog2(N_SRC+1)-1:0]]);

  // R4
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> out_en);

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    if (EDGE_SEL[i]) begin : g_e
      // R7
      edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[i] && !(wr_en && wr_addr == A_ACK && wr_data[i]) |=> status[i]);
    end else begin : g_l
      // R8
      level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode && irq_in[i] |=> status[i]);
    end
  end
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int BUS_W = 32;
  localparam int N_SRC = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_SRC-1:0] irq_in = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [BUS_W-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [BUS_W-1:0] rd_data;
  logic             irq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.BUS_W(BUS_W), .N_SRC(N_SRC), .EDGE_SEL(8'h0F)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out));

  // fields: irq_in[79:72] wr[71] waddr[70:68] wdata[67:36] raddr[35:33] exp[32:1] eirq[0]
  // offsets: 0 status 1 pending 2 enable 3 ack 4 vector 5 master 6 set; lines 0-3 edge, 4-7 level
  localparam int NSTEP = 22;
  localparam logic [79:0] TBL [NSTEP] = '{
    {8'h00, 1'b1, 3'd2, 32'hFF, 3'd2, 32'hFF, 1'b0},        // R9 enable rw
    {8'h00, 1'b1, 3'd6, 32'h24, 3'd0, 32'h24, 1'b0},        // R6 set, R4 out off
    {8'h00, 1'b1, 3'd5, 32'h01, 3'd4, 32'h02, 1'b1},        // R2 R4
    {8'h01, 1'b1, 3'd3, 32'h04, 3'd0, 32'h20, 1'b1},        // R5 hw line ignored
    {8'h01, 1'b0, 3'd0, 32'h00, 3'd4, 32'h05, 1'b1},        // R2
    {8'h00, 1'b1, 3'd3, 32'h20, 3'd0, 32'h00, 1'b0},        // R4
    {8'h00, 1'b1, 3'd5, 32'h03, 3'd5, 32'h03, 1'b0},        // R5
    {8'h00, 1'b1, 3'd6, 32'hFF, 3'd0, 32'h00, 1'b0},        // R6 ignored
    {8'h08, 1'b0, 3'd0, 32'h00, 3'd0, 32'h08, 1'b1},        // R7 rise
    {8'h00, 1'b0, 3'd0, 32'h00, 3'd0, 32'h08, 1'b1},        // R7 hold
    {8'h10, 1'b0, 3'd0, 32'h00, 3'd4, 32'h03, 1'b1},        // R2 R8
    {8'h10, 1'b1, 3'd3, 32'h18, 3'd0, 32'h10, 1'b1},        // R8 ack ignored while high
    {8'h00, 1'b0, 3'd0, 32'h00, 3'd0, 32'h10, 1'b1},        // R8
    {8'h00, 1'b1, 3'd3, 32'h10, 3'd0, 32'h00, 1'b0},        // R8 cleared
    {8'h03, 1'b1, 3'd2, 32'h02, 3'd1, 32'h02, 1'b1},        // R3
    {8'h03, 1'b0, 3'd0, 32'h00, 3'd4, 32'h01, 1'b1},        // R3 masked bit 0
    {8'h03, 1'b1, 3'd5, 32'h02, 3'd5, 32'h02, 1'b0},        // R4
    {8'h03, 1'b1, 3'd5, 32'h01, 3'd5, 32'h03, 1'b1},        // R5 sticky
    {8'h03, 1'b1, 3'd2, 32'h00, 3'd4, 32'hFFFFFFFF, 1'b0},  // R2 R3
    {8'h00, 1'b1, 3'd3, 32'hFF, 3'd0, 32'h00, 1'b0},        // R7 ack
    {8'h01, 1'b1, 3'd3, 32'h01, 3'd0, 32'h01, 1'b0},        // R7 rise beats ack
    {8'h01, 1'b1, 3'd2, 32'h01, 3'd4, 32'h00, 1'b1}         // R2
  };

  task automatic check(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [BUS_W-1:0] exp);
    rd_addr = a;
    #0.5;
    check(req, rd_data, exp);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1", 3'd0, 32'h0);
    rd_chk("R1", 3'd2, 32'h0);
    rd_chk("R1", 3'd5, 32'h0);
    rd_chk("R1", 3'd4, 32'hFFFFFFFF);
    check("R1", {31'b0, irq_out}, 32'h0);
    rd_chk("R9", 3'd7, 32'h0);

    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      irq_in  = TBL[s][79:72];
      wr_en   = TBL[s][71];
      wr_addr = TBL[s][70:68];
      wr_data = TBL[s][67:36];
      rd_addr = TBL[s][35:33];
      @(posedge clk);
      #1 wr_en = 1'b0;
      #0.5;
      check($sformatf("step %0d R2-table", s), rd_data, TBL[s][32:1]);
      check($sformatf("step %0d R4 irq", s), {31'b0, irq_out}, {31'b0, TBL[s][0]});
    end

    // R1 reset mid-run, R5 hardware mode cleared, R6 set path back
    @(negedge clk);
    rst_n = 1'b0;
    irq_in = '0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    rd_chk("R1", 3'd0, 32'h0);
    rd_chk("R1", 3'd5, 32'h0);
    rd_chk("R1", 3'd4, 32'hFFFFFFFF);
    check("R1", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'h80;
    @(posedge clk);
    #1 wr_en = 1'b0;
    rd_chk("R6", 3'd0, 32'h80);
    rd_chk("R9 ack reads 0", 3'd3, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule